// File: doc/BRIEF.md
# Fetch Target Buffer

This block tells the fetch stage where to fetch next, before the current instruction is decoded. Each cycle the fetch PC is looked up in a direct-mapped table. If the table holds a valid entry for exactly that PC and the entry's direction counter leans taken, the stored target is returned as the next fetch address. In every other case the next fetch address is the sequential one, PC+4.

The table learns from the execute stage. When a branch resolves, the resolve port carries the instruction's PC, its real target, whether it was taken, whether it is a control transfer at all, and the next PC that fetch actually used for it. From these the block finds the real successor PC. It raises a mispredict flag when fetch went elsewhere, and it supplies the corrected PC. It then corrects its own entry. Only taken control transfers can create an entry. Because the full PC is kept as the tag, ordinary instructions can never hit. A resolve that misses the table and was not taken leaves the table as it is.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns lookupPc+4.
- R2: An entry is selected by PC bits [IDX_W+1:2] (bits [5:2] with defaults). A later allocation at the same index replaces the older entry, so the older PC then misses. Entries at other indices are not touched.
- R3: A hit requires the stored PC to equal the whole lookup PC. A PC that shares the index but differs in other bits gets lookupPc+4.
- R4: A resolve with resIsCtrl=0 never changes the table, whatever its taken flag and target.
- R5: A taken control resolve that misses allocates an entry with counter value 2 (weakly taken), so the next lookup of that PC returns resTarget.
- R6: A not-taken control resolve that misses allocates nothing.
- R7: The resolved next PC is resTarget when resIsCtrl and resTaken are both 1, and resPc+4 otherwise. fixPc always shows this value. mispredict is 1 exactly when resValid is 1 and resPredNext differs from it.
- R8: On a hit, a control resolve moves the 2-bit counter up when taken and down when not taken, saturating at 3 and at 0. A lookup predicts taken only when the counter is 2 or 3.
- R9: A taken control resolve that hits overwrites the stored target with resTarget.
- R10: A lookup sees the result of a resolve in the cycle right after the clock edge that accepted that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; clears all valid bits |
| lookupPc | input | PC_W | Current fetch PC |
| nextPc | output | PC_W | Predicted next fetch PC |
| resValid | input | 1 | A resolved instruction is presented this cycle |
| resPc | input | PC_W | PC of the resolved instruction |
| resTarget | input | PC_W | Actual target of the resolved instruction |
| resTaken | input | 1 | The resolved instruction was taken |
| resIsCtrl | input | 1 | The resolved instruction is a branch or jump |
| resPredNext | input | PC_W | Next PC that fetch used after this instruction |
| mispredict | output | 1 | Fetch followed the wrong path |
| fixPc | output | PC_W | Correct next PC for the resolved instruction |

## Verification
A wrong valid bit, tag or target is visible at nextPc on the first lookup of the affected PC after the faulty write. The bench therefore follows every resolve with a lookup in the very next cycle. A counter that is off by one shows up only when it crosses the 1/2 boundary, so the counter is walked into both saturation limits and back out again. Each step is checked at nextPc, and mispredict is checked as each resolve arrives. Replacement and tag aliasing are checked with PCs 64 bytes apart, which share an index.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Write strobes from the control to the table datapath
  typedef struct packed {
    logic alloc;      // create an entry at the resolve index
    logic bump;       // move the counter of the hit entry
    logic takenDir;   // direction of the counter move
    logic setTarget;  // overwrite the stored target of the hit entry
  } btbStrobeT;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  input  logic [PC_W-1:0] resPc,
  input  logic [PC_W-1:0] resTarget,
  input  btbStrobeT       strobes,
  output logic [PC_W-1:0] nextPc,
  output logic            resHit
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + 1;

  logic [DEPTH-1:0] validQ;
  logic [PC_W-1:0]  tagQ [DEPTH];
  logic [PC_W-1:0]  tgtQ [DEPTH];
  logic [1:0]       ctrQ [DEPTH];

  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] rsIdx;
  logic             lkHit;
  logic [1:0]       ctrNext;

  assign lkIdx = lookupPc[IDX_HI:IDX_LO];
  assign rsIdx = resPc[IDX_HI:IDX_LO];

  assign lkHit  = validQ[lkIdx] && (tagQ[lkIdx] == lookupPc);
  assign resHit = validQ[rsIdx] && (tagQ[rsIdx] == resPc);

  assign nextPc = (lkHit && ctrQ[lkIdx][1]) ? tgtQ[lkIdx] : lookupPc + PC_W'(4);

  always_comb begin
    ctrNext = ctrQ[rsIdx];
    if (strobes.takenDir) begin
      if (ctrQ[rsIdx] != 2'b11) ctrNext = ctrQ[rsIdx] + 2'b01;
    end else begin
      if (ctrQ[rsIdx] != 2'b00) ctrNext = ctrQ[rsIdx] - 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobes.alloc) begin
      validQ[rsIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.alloc) begin
      tagQ[rsIdx] <= resPc;
      tgtQ[rsIdx] <= resTarget;
      ctrQ[rsIdx] <= 2'b10;
    end else if (strobes.bump) begin
      ctrQ[rsIdx] <= ctrNext;
      if (strobes.setTarget) tgtQ[rsIdx] <= resTarget;
    end
  end
endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            resValid,
  input  logic            resIsCtrl,
  input  logic            resTaken,
  input  logic            resHit,
  input  logic [PC_W-1:0] resPc,
  input  logic [PC_W-1:0] resTarget,
  input  logic [PC_W-1:0] resPredNext,
  output btbStrobeT       strobes,
  output logic            mispredict,
  output logic [PC_W-1:0] fixPc
);
  logic ctrlEvt;

  assign ctrlEvt = resValid && resIsCtrl;

  always_comb begin
    strobes.alloc     = ctrlEvt && resTaken && !resHit;
    strobes.bump      = ctrlEvt && resHit;
    strobes.takenDir  = resTaken;
    strobes.setTarget = ctrlEvt && resHit && resTaken;
  end

  assign fixPc      = (resIsCtrl && resTaken) ? resTarget : resPc + PC_W'(4);
  assign mispredict = resValid && (resPredNext != fixPc);
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic [PC_W-1:0] nextPc,
  input  logic            resValid,
  input  logic [PC_W-1:0] resPc,
  input  logic [PC_W-1:0] resTarget,
  input  logic            resTaken,
  input  logic            resIsCtrl,
  input  logic [PC_W-1:0] resPredNext,
  output logic            mispredict,
  output logic [PC_W-1:0] fixPc
);
  btbStrobeT strobes;
  logic      resHit;

  btb_ctrl #(.PC_W(PC_W)) u_ctrl (
    .resValid(resValid), .resIsCtrl(resIsCtrl), .resTaken(resTaken),
    .resHit(resHit), .resPc(resPc), .resTarget(resTarget),
    .resPredNext(resPredNext), .strobes(strobes),
    .mispredict(mispredict), .fixPc(fixPc)
  );

  btb_datapath #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .resPc(resPc),
    .resTarget(resTarget), .strobes(strobes), .nextPc(nextPc),
    .resHit(resHit)
  );
endmodule

// File: rtl/branch_target_buffer_chk.sv
module branch_target_buffer_chk
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookupPc,
  input logic [PC_W-1:0] nextPc,
  input logic            resValid,
  input logic            resIsCtrl,
  input logic [PC_W-1:0] resPc,
  input logic [PC_W-1:0] resTarget,
  input logic [PC_W-1:0] resPredNext,
  input logic            mispredict,
  input logic [PC_W-1:0] fixPc,
  input btbStrobeT       strobes
);
  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
    $rose(rstN) |-> nextPc == lookupPc + PC_W'(4)); // R1

  AST_NONCTRL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resIsCtrl) |-> !(strobes.alloc || strobes.bump || strobes.setTarget)); // R4

  AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.alloc && lookupPc == resPc) ##1 $stable(lookupPc) |-> nextPc == $past(resTarget)); // R5

  AST_MISPRED_NEEDS_RES: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> resValid); // R7

  AST_MISPRED_FIX_DIFFERS: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> fixPc != resPredNext); // R7
endmodule

bind branch_target_buffer branch_target_buffer_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .nextPc(nextPc),
  .resValid(resValid), .resIsCtrl(resIsCtrl), .resPc(resPc),
  .resTarget(resTarget), .resPredNext(resPredNext),
  .mispredict(mispredict), .fixPc(fixPc), .strobes(strobes)
);

// File: tb/branch_target_buffer_test.sv
module branch_target_buffer_test;
  localparam int PC_W = 32;

  typedef struct {
    bit        chkNext;
    bit [31:0] expNext;
    bit        chkRes;
    bit        expMis;
    bit [31:0] expFix;
    int        req;
  } expT;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] lookupPc = '0;
  logic [PC_W-1:0] nextPc;
  logic            resValid = 1'b0;
  logic [PC_W-1:0] resPc = '0;
  logic [PC_W-1:0] resTarget = '0;
  logic            resTaken = 1'b0;
  logic            resIsCtrl = 1'b0;
  logic [PC_W-1:0] resPredNext = '0;
  logic            mispredict;
  logic [PC_W-1:0] fixPc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  expT q[$];

  always #5 clk = ~clk;

  branch_target_buffer #(.PC_W(PC_W), .IDX_W(4)) uut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .nextPc(nextPc),
    .resValid(resValid), .resPc(resPc), .resTarget(resTarget),
    .resTaken(resTaken), .resIsCtrl(resIsCtrl), .resPredNext(resPredNext),
    .mispredict(mispredict), .fixPc(fixPc)
  );

  // Monitor: compares 1 ns before the next rising edge
  always @(negedge clk) begin
    expT it;
    #4;
    if (q.size() > 0) begin
      it = q.pop_front();
      if (it.chkNext) begin
        checks++;
        if (nextPc !== it.expNext) begin
          fails++;
          $display("FAIL R%0d nextPc actual %h expected %h", it.req, nextPc, it.expNext);
        end
      end
      checks++;
      if (mispredict !== it.expMis) begin
        fails++;
        $display("FAIL R%0d mispredict actual %b expected %b", it.req, mispredict, it.expMis);
      end
      if (it.chkRes) begin
        checks++;
        if (fixPc !== it.expFix) begin
          fails++;
          $display("FAIL R%0d fixPc actual %h expected %h", it.req, fixPc, it.expFix);
        end
      end
    end
  end

  task automatic look(input logic [31:0] pc, input logic [31:0] expN, input int req);
    expT it;
    @(negedge clk);
    lookupPc = pc; resValid = 1'b0;
    it.chkNext = 1'b1; it.expNext = expN; it.chkRes = 1'b0;
    it.expMis = 1'b0; it.expFix = '0; it.req = req;
    q.push_back(it);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [31:0] tgt, input bit tk,
                         input bit ctl, input logic [31:0] pred, input int req);
    expT it;
    logic [31:0] realNext;
    realNext = (ctl && tk) ? tgt : pc + 32'd4;
    @(negedge clk);
    lookupPc = pc; resValid = 1'b1; resPc = pc; resTarget = tgt;
    resTaken = tk; resIsCtrl = ctl; resPredNext = pred;
    it.chkNext = 1'b0; it.expNext = '0; it.chkRes = 1'b1;
    it.expMis = (pred != realNext); it.expFix = realNext; it.req = req;
    q.push_back(it);
  endtask

  localparam logic [31:0] PA = 32'h0000_1000;
  localparam logic [31:0] PB = 32'h0000_1040;  // same index as PA
  localparam logic [31:0] PC2 = 32'h0000_1008; // different index
  localparam logic [31:0] TA = 32'h0000_2000;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    look(PA, PA + 4, 1);                 // R1
    look(32'h1234, 32'h1238, 1);         // R1
    resolve(PA, 32'h3000, 1, 0, PA + 4, 4);  // R4, R7: non-control, no mispredict
    look(PA, PA + 4, 4);                 // R4
    resolve(PA, TA, 0, 1, PA + 4, 6);    // R6
    look(PA, PA + 4, 6);                 // R6
    resolve(PA, TA, 1, 1, PA + 4, 7);    // R7: mispredict, fix TA
    look(PA, TA, 5);                     // R5, R10
    look(PB, PB + 4, 3);                 // R3: same index, other tag
    resolve(PA, TA, 1, 1, TA, 8);        // R8: ctr 3
    resolve(PA, TA, 1, 1, TA, 8);        // R8: saturate at 3
    resolve(PA, TA, 0, 1, TA, 7);        // R7: mispredict, ctr 2
    look(PA, TA, 8);                     // R8
    resolve(PA, TA, 0, 1, TA, 8);        // ctr 1
    look(PA, PA + 4, 8);                 // R8
    resolve(PA, TA, 0, 1, PA + 4, 8);    // ctr 0
    resolve(PA, TA, 0, 1, PA + 4, 8);    // ctr saturates at 0
    resolve(PA, TA, 1, 1, PA + 4, 8);    // ctr 1
    look(PA, PA + 4, 8);                 // R8: saturation at 0 held
    resolve(PA, TA, 1, 1, PA + 4, 8);    // ctr 2
    look(PA, TA, 8);                     // R8
    resolve(PA, 32'h4000, 1, 1, TA, 9);  // R9: new target
    look(PA, 32'h4000, 9);               // R9
    resolve(PB, 32'h5000, 1, 1, PB + 4, 2);  // R2: replaces PA
    look(PB, 32'h5000, 2);               // R2
    look(PA, PA + 4, 2);                 // R2: evicted
    resolve(PC2, 32'h6000, 1, 1, PC2 + 4, 2);
    look(PC2, 32'h6000, 2);              // R2
    look(PB, 32'h5000, 2);               // R2: other index untouched
    @(negedge clk);
    resValid = 1'b0;
    #6;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule